// File: doc/BRIEF.md
# Three-Bank Event Interrupt Aggregator

The aggregator gathers up to 96 single-cycle hardware event pulses into three 32-bit pending banks and turns them into three level-sensitive interrupt request lines, A, B and C. Each event arrives as a valid strobe with a 7-bit code. The upper two bits of the code pick the bank and the lower five bits pick the bit inside it. Each output line has its own set of three enable masks, one per bank. A line stays high for as long as any pending bit that its masks enable is still set.

Software reaches the pending and mask registers through a simple word port. Writing a pending register clears each bit written as 1 and leaves the bits written as 0 alone. One bit, bit 0 of bank 1, cannot be cleared this way and can only be held or set by hardware. Prioritising the three lines is left to the downstream interrupt controller.

Top module: `evagg_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every pending and mask register is zero, `irq_out` is 3'b000 and `reg_rdata` is zero.
- R2: When `evt_valid` is high and `evt_code[6:5]` is 0, 1 or 2, the edge sets bit `evt_code[4:0]` of pending bank `evt_code[6:5]`. All other pending bits keep their value.
- R3: An event whose `evt_code[6:5]` equals 3 changes no pending bit.
- R4: `irq_out[0]` is line A, `irq_out[1]` is line B and `irq_out[2]` is line C. Each line is registered. On the edge after a register update, the line becomes 1 if (pending & that line's mask) is nonzero in any bank, and 0 otherwise.
- R5: A write to pending bank k (address 4'b00kk) clears every bit written as 1. Bits written as 0 keep their value.
- R6: A write to pending bank 1 never clears bit 0 of that bank.
- R7: After a clear, a line stays high while any enabled pending bit remains in any of the three banks. It drops only when none remains.
- R8: A write to a mask register replaces its whole value. Address bits [3:2] equal to 1, 2 or 3 select the masks of line A, B or C, and bits [1:0] select the bank.
- R9: `reg_rdata` is registered. One edge after `reg_addr` is presented, it shows the value held at that address before that edge. Address bits [3:2] equal to 0 select the pending banks. A bank field of 3 reads zero, and writes to it change nothing.
- R10: If an event sets a pending bit on the same edge as a write that clears it, the bit ends up set.
- R11: A mask write that enables an already pending bit raises the line one edge after the mask register updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event strobe |
| evt_code | input | 7 | Event code: [6:5] bank, [4:0] bit |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address: [3:2] group, [1:0] bank |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | 3 | Interrupt lines {C, B, A} |

## Verification
A hardware event set and a software clear can land on the same edge, and they can target the same pending bit. The bench provokes this by raising an event while, in the same cycle, writing 1s over that bit and its neighbours. It then judges the outcome by reading the bank back: the event's bit must survive and the neighbours must be gone. The protected bit is exercised the same way. An all-ones clear is written to bank 1 while line A is enabled on that bit, and both the readback and line A must show the bit still set.

// File: rtl/evagg_pkg.sv
package evagg_pkg;
  localparam int EV_BANKS    = 3;
  localparam int EV_BITS     = 32;
  localparam int EV_OUTS     = 3;
  localparam int EV_PROT_BANK = 1;
  localparam int EV_PROT_BIT  = 0;
endpackage

// File: rtl/evagg_pend_bank.sv
module evagg_pend_bank #(
  parameter int BITS = 32,
  parameter logic [BITS-1:0] KEEP = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [BITS-1:0] set_vec,
  input  logic [BITS-1:0] clr_vec,
  output logic [BITS-1:0] pend
);
  // hardware set dominates a same-edge software clear
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~(clr_vec & ~KEEP)) | set_vec;
  end
endmodule

// File: rtl/evagg_irq_reduce.sv
module evagg_irq_reduce #(
  parameter int BANKS = 3,
  parameter int BITS  = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [BANKS*BITS-1:0] pend,
  input  logic [BANKS*BITS-1:0] mask,
  output logic                  irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(pend & mask);
  end
endmodule

// File: rtl/evagg_top.sv
module evagg_top
  import evagg_pkg::*;
#(
  parameter int BANKS = EV_BANKS,
  parameter int BITS  = EV_BITS,
  parameter int OUTS  = EV_OUTS,
  localparam int BIT_W  = $clog2(BITS),
  localparam int BANK_W = 2,
  localparam int CODE_W = BANK_W + BIT_W,
  localparam int GRP_W  = $clog2(OUTS + 1),
  localparam int ADDR_W = GRP_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_valid,
  input  logic [CODE_W-1:0] evt_code,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BITS-1:0]   reg_wdata,
  output logic [BITS-1:0]   reg_rdata,
  output logic [OUTS-1:0]   irq_out
);
  logic [BANK_W-1:0] ev_bank;
  logic [BIT_W-1:0]  ev_bit;
  logic [GRP_W-1:0]  grp;
  logic [BANK_W-1:0] bnk;
  logic [BANKS*BITS-1:0]           pend_flat;
  logic [OUTS-1:0][BANKS*BITS-1:0] mask_flat;
  logic [BITS-1:0]   rd_d;

  assign ev_bank = evt_code[CODE_W-1:BIT_W];
  assign ev_bit  = evt_code[BIT_W-1:0];
  assign grp     = reg_addr[ADDR_W-1:BANK_W];
  assign bnk     = reg_addr[BANK_W-1:0];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam logic [BITS-1:0] KEEP_M =
      (b == EV_PROT_BANK) ? (BITS'(1) << EV_PROT_BIT) : '0;
    logic [BITS-1:0] set_vec, clr_vec;
    assign set_vec = (evt_valid && ev_bank == BANK_W'(b)) ? (BITS'(1) << ev_bit) : '0;
    assign clr_vec = (reg_wr && grp == '0 && bnk == BANK_W'(b)) ? reg_wdata : '0;
    evagg_pend_bank #(.BITS(BITS), .KEEP(KEEP_M)) u_pend (
      .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec),
      .pend(pend_flat[b*BITS +: BITS])
    );
  end

  for (genvar o = 0; o < OUTS; o++) begin : g_out
    for (genvar b = 0; b < BANKS; b++) begin : g_mbank
      logic [BITS-1:0] m_q;
      always_ff @(posedge clk) begin
        if (rst) m_q <= '0;
        else if (reg_wr && grp == GRP_W'(o + 1) && bnk == BANK_W'(b)) m_q <= reg_wdata;
      end
      assign mask_flat[o][b*BITS +: BITS] = m_q;
    end
    evagg_irq_reduce #(.BANKS(BANKS), .BITS(BITS)) u_red (
      .clk(clk), .rst(rst), .pend(pend_flat), .mask(mask_flat[o]),
      .irq(irq_out[o])
    );
  end

  always_comb begin
    rd_d = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (bnk == BANK_W'(b)) begin
        if (grp == '0) rd_d = pend_flat[b*BITS +: BITS];
        for (int o = 0; o < OUTS; o++)
          if (grp == GRP_W'(o + 1)) rd_d = mask_flat[o][b*BITS +: BITS];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_d;
  end
endmodule

// File: rtl/evagg_chk.sv
module evagg_chk #(
  parameter int BANKS  = 3,
  parameter int BITS   = 32,
  parameter int OUTS   = 3,
  parameter int CODE_W = 7,
  parameter int ADDR_W = 4
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            evt_valid,
  input logic [CODE_W-1:0]               evt_code,
  input logic                            reg_wr,
  input logic [ADDR_W-1:0]               reg_addr,
  input logic [BITS-1:0]                 reg_wdata,
  input logic [OUTS-1:0]                 irq_out,
  input logic [BANKS*BITS-1:0]           pend_flat,
  input logic [OUTS-1:0][BANKS*BITS-1:0] mask_flat
);
  localparam int BIT_W = CODE_W - 2;
  localparam int PROT  = evagg_pkg::EV_PROT_BANK * BITS + evagg_pkg::EV_PROT_BIT;
  localparam logic [ADDR_W-1:0] PROT_ADDR = ADDR_W'(evagg_pkg::EV_PROT_BANK);

  logic ev_real;
  assign ev_real = evt_valid && (int'(evt_code[CODE_W-1:BIT_W]) < BANKS);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> irq_out == '0); // R1

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
    ev_real |=> pend_flat[$past(evt_code)]); // R2

  AST_BANK3_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !ev_real && !reg_wr) |=> $stable(pend_flat)); // R3

  AST_CLEAR_BANK0: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == '0 && !evt_valid) |=>
      (pend_flat[BITS-1:0] & $past(reg_wdata)) == '0); // R5

  AST_PROTECTED_BIT: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == PROT_ADDR && pend_flat[PROT]) |=> pend_flat[PROT]); // R6

  for (genvar o = 0; o < OUTS; o++) begin : g_line
    AST_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
      (|(pend_flat & mask_flat[o])) |=> irq_out[o]); // R4
    AST_LINE_LOW: assert property (@(posedge clk) disable iff (rst)
      !(|(pend_flat & mask_flat[o])) |=> !irq_out[o]); // R7
  end
endmodule

bind evagg_top evagg_chk #(
  .BANKS(BANKS), .BITS(BITS), .OUTS(OUTS), .CODE_W(CODE_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_code(evt_code),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .irq_out(irq_out), .pend_flat(pend_flat), .mask_flat(mask_flat)
);

// File: tb/tb_evagg_top.sv
module tb_evagg_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_valid = 1'b0;
  logic [6:0]  evt_code = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  irq_out;

  evagg_top dut (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_code(evt_code),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  event  mon_ev;
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  bit [31:0] m_pend [3];
  bit [31:0] m_mask [3][3];

  always @(mon_ev) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb.pop_front();
      act = it.is_irq ? {29'b0, irq_out} : reg_rdata;
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [2:0] model_irq();
    logic [2:0] r = '0;
    for (int o = 0; o < 3; o++)
      for (int b = 0; b < 3; b++)
        if ((m_pend[b] & m_mask[o][b]) != 0) r[o] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] model_reg(input logic [3:0] a);
    if (a[1:0] == 2'd3) return '0;
    if (a[3:2] == 2'd0) return m_pend[a[1:0]];
    return m_mask[a[3:2] - 1][a[1:0]];
  endfunction

  task automatic drive(input bit ev, input logic [6:0] code,
                       input bit wr, input logic [3:0] a, input logic [31:0] d);
    evt_valid = ev; evt_code = code; reg_wr = wr; reg_addr = a; reg_wdata = d;
    if (wr && a[1:0] != 2'd3) begin
      if (a[3:2] == 2'd0) m_pend[a[1:0]] &= ~(d & ((a[1:0] == 2'd1) ? 32'hFFFF_FFFE : 32'hFFFF_FFFF));
      else m_mask[a[3:2] - 1][a[1:0]] = d;
    end
    if (ev && code[6:5] != 2'd3) m_pend[code[6:5]] |= (32'd1 << code[4:0]);
    step();
    evt_valid = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic chk_irq(input string tag);
    item_t it;
    step();
    it.is_irq = 1'b1; it.exp = {29'b0, model_irq()}; it.tag = tag;
    sb.push_back(it);
    -> mon_ev;
    #1;
  endtask

  task automatic chk_reg(input logic [3:0] a, input string tag);
    item_t it;
    it.is_irq = 1'b0; it.exp = model_reg(a); it.tag = tag;
    reg_addr = a;
    step();
    sb.push_back(it);
    -> mon_ev;
    #1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    item_t it;
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1: reset state on outputs and registers
    it.is_irq = 1'b1; it.exp = '0; it.tag = "R1 irq after reset";
    sb.push_back(it); -> mon_ev; #1;
    it.is_irq = 1'b0; it.exp = '0; it.tag = "R1 rdata after reset";
    sb.push_back(it); -> mon_ev; #1;
    chk_reg(4'b0000, "R1 pending bank0");
    chk_reg(4'b0100, "R1 mask A bank0");

    // R2: events pick bank and bit
    drive(1, 7'd5, 0, 4'd0, 0);
    drive(1, 7'd71, 0, 4'd0, 0);
    chk_reg(4'b0000, "R2 bank0 bit5");
    chk_reg(4'b0010, "R2 bank2 bit7");
    chk_reg(4'b0001, "R2 bank1 untouched");

    // R3: bank field 3 ignored
    drive(1, 7'h63, 0, 4'd0, 0);
    chk_reg(4'b0000, "R3 bank0 after bank3 event");
    chk_reg(4'b0010, "R3 bank2 after bank3 event");

    // R8 / R9: mask write and readback, hole at bank 3
    drive(0, 0, 1, 4'b1010, 32'h0000_0080);
    chk_reg(4'b1010, "R8 mask B bank2 readback");
    drive(0, 0, 1, 4'b0111, 32'hDEAD_BEEF);
    chk_reg(4'b0111, "R9 bank3 hole reads zero");

    // R4: line B from bank2
    chk_irq("R4 line B only");

    // R11: enabling an already pending bit
    drive(0, 0, 1, 4'b0100, 32'h0000_0020);
    chk_irq("R11 line A after mask write");

    // R5 / R7: clear bank0 bit5, A drops, B stays
    drive(0, 0, 1, 4'b0000, 32'h0000_0020);
    chk_irq("R7 line A drops, B stays");
    chk_reg(4'b0000, "R5 bank0 cleared");

    // R7: line C across banks
    drive(1, 7'd1, 0, 0, 0);
    drive(1, 7'd35, 0, 0, 0);
    drive(0, 0, 1, 4'b1100, 32'h0000_0002);
    drive(0, 0, 1, 4'b1101, 32'h0000_0008);
    chk_irq("R7 line C set");
    drive(0, 0, 1, 4'b0000, 32'h0000_0002);
    chk_irq("R7 line C held by bank1");
    drive(0, 0, 1, 4'b0001, 32'h0000_0008);
    chk_irq("R7 line C drops when none left");

    // R6: protected bit
    drive(1, 7'd32, 0, 0, 0);
    drive(0, 0, 1, 4'b0101, 32'h0000_0001);
    drive(0, 0, 1, 4'b0001, 32'hFFFF_FFFF);
    chk_reg(4'b0001, "R6 bank1 bit0 survives clear");
    chk_irq("R6 line A held by protected bit");

    // R10: set and clear on the same edge
    drive(1, 7'd3, 0, 0, 0);
    drive(1, 7'd9, 1, 4'b0000, 32'h0000_0208);
    chk_reg(4'b0000, "R10 set wins over clear");

    // R5: zero write keeps, ones clear
    drive(0, 0, 1, 4'b0010, 32'h0);
    chk_reg(4'b0010, "R5 zero write keeps bits");
    drive(0, 0, 1, 4'b0010, 32'hFFFF_FFFF);
    chk_reg(4'b0010, "R5 ones clear bank2");
    chk_irq("R4 line B falls");

    #1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule